// File: doc/BRIEF.md
# Mailbox Interrupt Flag Controller

This block sits beside a memory shared by one primary port and two secondary ports and turns accesses to two reserved mailbox words into interrupt flags. A secondary that writes the to-primary mailbox word (address 0xFFE) raises an interrupt toward the primary. A primary write to the to-secondary mailbox word (address 0xFFF) raises an interrupt toward the secondary picked by the primary's bank-select line. The receiving side removes its own interrupt by touching the same mailbox word, whether it reads or writes it.

The flags are pairwise: each secondary talks only to the primary, and the primary reaches either secondary through its two active-low bank selects. Bit 0 of the bank select stands for secondary 0 and bit 1 for secondary 1. All four flags are registered, and their interrupt outputs are active low.

Top module: `mbox_irq`

## Requirements
- R1: After reset, all four interrupt outputs are high (inactive).
- R2: A write by secondary k (enable low, write select low) to address 0xFFE drives `priIrqFromSec<k>N` low from the next clock edge on.
- R3: A primary access to address 0xFFE with `priSelN[k]` low clears the flag from secondary k at the next edge, whatever `priWrN` is.
- R4: A primary write (`priWrN` low) to address 0xFFF with `priSelN[k]` low drives `sec<k>IrqN` low from the next clock edge on.
- R5: An access by secondary k to address 0xFFF with its enable low clears `sec<k>IrqN` to high at the next edge, whatever its write select is.
- R6: When a set and a clear of the same flag fall in the same cycle, the flag ends up set.
- R7: Accesses to any other address, accesses from a port whose enable or bank select is high, secondary reads of 0xFFE and primary reads of 0xFFF leave every flag unchanged.
- R8: Each flag changes only through its own set and clear conditions. An access aimed at one flag leaves the other three as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| priSelN | input | 2 | Primary bank selects, active low; bit k addresses secondary k |
| priWrN | input | 1 | Primary write select, low = write |
| priAddr | input | 12 | Primary address |
| sec0EnN | input | 1 | Secondary 0 enable, active low |
| sec0WrN | input | 1 | Secondary 0 write select, low = write |
| sec0Addr | input | 12 | Secondary 0 address |
| sec1EnN | input | 1 | Secondary 1 enable, active low |
| sec1WrN | input | 1 | Secondary 1 write select, low = write |
| sec1Addr | input | 12 | Secondary 1 address |
| priIrqFromSec0N | output | 1 | Interrupt to the primary from secondary 0, active low |
| priIrqFromSec1N | output | 1 | Interrupt to the primary from secondary 1, active low |
| sec0IrqN | output | 1 | Interrupt to secondary 0, active low |
| sec1IrqN | output | 1 | Interrupt to secondary 1, active low |

## Verification
Each interrupt output is a direct view of one flag register. A wrong flag state therefore shows up at the ports one clock after the access that caused it. It stays visible until the matching set or clear arrives. A decode that mixes up the secondaries shows as the wrong output changing in that same cycle. A lost collision shows as a missing interrupt right after the collision cycle.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;
  localparam int MB_NUM_SEC   = 2;
  localparam int MB_NUM_FLAGS = 2 * MB_NUM_SEC;

  // Flags [0 .. MB_NUM_SEC-1]: secondary k -> primary
  // Flags [MB_NUM_SEC .. MB_NUM_FLAGS-1]: primary -> secondary k
  typedef struct packed {
    logic [MB_NUM_FLAGS-1:0] set;
    logic [MB_NUM_FLAGS-1:0] clr;
  } flagStrobes_t;
endpackage

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl
  import mbox_irq_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int TO_PRI_MBOX = 'hFFE,
  parameter int TO_SEC_MBOX = 'hFFF
) (
  input  logic [MB_NUM_SEC-1:0]        priSelN,
  input  logic                         priWrN,
  input  logic [ADDR_W-1:0]            priAddr,
  input  logic [MB_NUM_SEC-1:0]        secEnN,
  input  logic [MB_NUM_SEC-1:0]        secWrN,
  input  logic [MB_NUM_SEC*ADDR_W-1:0] secAddrFlat,
  output flagStrobes_t                 strobes
);
  localparam logic [ADDR_W-1:0] PRI_BOX = ADDR_W'(TO_PRI_MBOX);
  localparam logic [ADDR_W-1:0] SEC_BOX = ADDR_W'(TO_SEC_MBOX);

  logic                    priAtPriBox;
  logic                    priWritesSecBox;
  logic [MB_NUM_FLAGS-1:0] setVec;
  logic [MB_NUM_FLAGS-1:0] clrVec;

  assign priAtPriBox     = (priAddr == PRI_BOX);
  assign priWritesSecBox = !priWrN && (priAddr == SEC_BOX);

  for (genvar k = 0; k < MB_NUM_SEC; k++) begin : g_sec
    logic [ADDR_W-1:0] secAddr;
    logic              secActive;
    assign secAddr   = secAddrFlat[k*ADDR_W +: ADDR_W];
    assign secActive = !secEnN[k];

    // secondary k -> primary
    assign setVec[k] = secActive && !secWrN[k] && (secAddr == PRI_BOX);
    assign clrVec[k] = !priSelN[k] && priAtPriBox;

    // primary -> secondary k
    assign setVec[MB_NUM_SEC+k] = !priSelN[k] && priWritesSecBox;
    assign clrVec[MB_NUM_SEC+k] = secActive && (secAddr == SEC_BOX);
  end

  assign strobes.set = setVec;
  assign strobes.clr = clrVec;
endmodule

// File: rtl/mbox_irq_flags.sv
module mbox_irq_flags
  import mbox_irq_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  flagStrobes_t            strobes,
  output logic [MB_NUM_FLAGS-1:0] flagQ
);
  // Set has priority over clear so that a notification is never dropped.
  always_ff @(posedge clk) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= strobes.set | (flagQ & ~strobes.clr);
  end

  for (genvar f = 0; f < MB_NUM_FLAGS; f++) begin : g_chk
    // R2 / R4: a set strobe raises the flag at the next edge
    p_set_raises_r2: assert property (@(posedge clk) disable iff (!rstN)
      strobes.set[f] |=> flagQ[f]);
    // R3 / R5: a lone clear strobe lowers the flag at the next edge
    p_clr_lowers_r3: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.clr[f] && !strobes.set[f]) |=> !flagQ[f]);
    // R6: a collision leaves the flag set
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.clr[f] && strobes.set[f]) |=> flagQ[f]);
    // R7: with no strobe the flag keeps its value
    p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
      (!strobes.clr[f] && !strobes.set[f]) |=> $stable(flagQ[f]));
  end
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq
  import mbox_irq_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int TO_PRI_MBOX = 'hFFE,
  parameter int TO_SEC_MBOX = 'hFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        priSelN,
  input  logic              priWrN,
  input  logic [ADDR_W-1:0] priAddr,
  input  logic              sec0EnN,
  input  logic              sec0WrN,
  input  logic [ADDR_W-1:0] sec0Addr,
  input  logic              sec1EnN,
  input  logic              sec1WrN,
  input  logic [ADDR_W-1:0] sec1Addr,
  output logic              priIrqFromSec0N,
  output logic              priIrqFromSec1N,
  output logic              sec0IrqN,
  output logic              sec1IrqN
);
  flagStrobes_t            strobes;
  logic [MB_NUM_FLAGS-1:0] flagQ;

  mbox_irq_ctrl #(
    .ADDR_W(ADDR_W), .TO_PRI_MBOX(TO_PRI_MBOX), .TO_SEC_MBOX(TO_SEC_MBOX)
  ) u_ctrl (
    .priSelN    (priSelN),
    .priWrN     (priWrN),
    .priAddr    (priAddr),
    .secEnN     ({sec1EnN, sec0EnN}),
    .secWrN     ({sec1WrN, sec0WrN}),
    .secAddrFlat({sec1Addr, sec0Addr}),
    .strobes    (strobes)
  );

  mbox_irq_flags u_flags (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .flagQ  (flagQ)
  );

  assign priIrqFromSec0N = ~flagQ[0];
  assign priIrqFromSec1N = ~flagQ[1];
  assign sec0IrqN        = ~flagQ[MB_NUM_SEC];
  assign sec1IrqN        = ~flagQ[MB_NUM_SEC+1];
endmodule

// File: tb/mbox_irq_test.sv
module mbox_irq_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  priSelN = 2'b11;
  logic        priWrN = 1'b1;
  logic [11:0] priAddr = '0;
  logic        sec0EnN = 1'b1, sec0WrN = 1'b1, sec1EnN = 1'b1, sec1WrN = 1'b1;
  logic [11:0] sec0Addr = '0, sec1Addr = '0;
  logic        priIrqFromSec0N, priIrqFromSec1N, sec0IrqN, sec1IrqN;

  int    vecCnt = 0;
  int    failCnt = 0;
  string tag = "R1";
  bit    model [4];   // 0,1: to primary from sec k; 2,3: to sec k
  bit    done = 1'b0;

  always #2 clk = ~clk;

  mbox_irq uut (.*);

  // Reference model: evaluate the rules at each edge, compare 1 ns later.
  always @(posedge clk) begin
    bit nxt [4];
    bit secAct [2];
    bit secWr [2];
    logic [11:0] sa [2];
    secAct[0] = !sec0EnN; secAct[1] = !sec1EnN;
    secWr[0]  = !sec0WrN; secWr[1]  = !sec1WrN;
    sa[0] = sec0Addr;     sa[1] = sec1Addr;
    for (int k = 0; k < 2; k++) begin
      bit s1, c1, s2, c2;
      s1 = secAct[k] && secWr[k] && sa[k] == 12'hFFE;
      c1 = !priSelN[k] && priAddr == 12'hFFE;
      s2 = !priSelN[k] && !priWrN && priAddr == 12'hFFF;
      c2 = secAct[k] && sa[k] == 12'hFFF;
      nxt[k]   = s1 ? 1'b1 : (c1 ? 1'b0 : model[k]);
      nxt[k+2] = s2 ? 1'b1 : (c2 ? 1'b0 : model[k+2]);
    end
    for (int i = 0; i < 4; i++) model[i] = rstN ? nxt[i] : 1'b0;
    #1;
    if (rstN && !done) begin
      logic [3:0] act, exp;
      act = {sec1IrqN, sec0IrqN, priIrqFromSec1N, priIrqFromSec0N};
      exp = {!model[3], !model[2], !model[1], !model[0]};
      vecCnt++;
      if (act !== exp) begin
        failCnt++;
        $display("FAIL %s: outputs actual %b expected %b at %0t", tag, act, exp, $time);
      end
    end
  end

  task automatic idle();
    priSelN = 2'b11; priWrN = 1'b1; priAddr = 12'h000;
    sec0EnN = 1'b1; sec0WrN = 1'b1; sec0Addr = 12'h000;
    sec1EnN = 1'b1; sec1WrN = 1'b1; sec1Addr = 12'h000;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic priAcc(input logic [1:0] sel, input logic wr, input logic [11:0] a);
    idle(); priSelN = sel; priWrN = ~wr; priAddr = a; step();
  endtask

  task automatic secAcc(input int k, input logic en, input logic wr, input logic [11:0] a);
    idle();
    if (k == 0) begin sec0EnN = ~en; sec0WrN = ~wr; sec0Addr = a; end
    else        begin sec1EnN = ~en; sec1WrN = ~wr; sec1Addr = a; end
    step();
  endtask

  initial begin
    idle();
    repeat (3) step();
    rstN = 1'b1;
    step();
    // R1: reset state
    vecCnt++;
    if ({sec1IrqN, sec0IrqN, priIrqFromSec1N, priIrqFromSec0N} !== 4'b1111) begin
      failCnt++;
      $display("FAIL R1: outputs actual %b expected 1111",
               {sec1IrqN, sec0IrqN, priIrqFromSec1N, priIrqFromSec0N});
    end
    tag = "R2"; secAcc(0, 1, 1, 12'hFFE); secAcc(1, 1, 1, 12'hFFE); idle(); step();
    tag = "R3"; priAcc(2'b10, 0, 12'hFFE); priAcc(2'b01, 1, 12'hFFE); idle(); step();
    tag = "R4"; priAcc(2'b10, 1, 12'hFFF); priAcc(2'b01, 1, 12'hFFF); idle(); step();
    tag = "R5"; secAcc(0, 1, 0, 12'hFFF); secAcc(1, 1, 1, 12'hFFF); idle(); step();
    tag = "R8"; secAcc(1, 1, 1, 12'hFFE); priAcc(2'b10, 1, 12'hFFF);
    priAcc(2'b10, 0, 12'hFFE); secAcc(0, 1, 0, 12'hFFF); idle(); step();
    tag = "R6";
    idle(); sec0EnN = 0; sec0WrN = 0; sec0Addr = 12'hFFE; priSelN = 2'b10; priAddr = 12'hFFE; step();
    idle(); sec1EnN = 0; sec1Addr = 12'hFFF; priSelN = 2'b01; priWrN = 0; priAddr = 12'hFFF; step();
    idle(); step();
    tag = "R7";
    secAcc(0, 1, 0, 12'hFFE); priAcc(2'b10, 0, 12'hFFF); secAcc(1, 0, 1, 12'hFFE);
    priAcc(2'b11, 1, 12'hFFF); priAcc(2'b11, 0, 12'hFFE); secAcc(1, 0, 0, 12'hFFF);
    secAcc(0, 1, 1, 12'hFFD); priAcc(2'b00, 1, 12'h7FF); secAcc(1, 1, 1, 12'h123);
    idle(); step();
    tag = "R8";
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] pick [4];
      pick[0] = 12'hFFE; pick[1] = 12'hFFF; pick[2] = 12'hFFD; pick[3] = 12'($urandom);
      priSelN  = 2'($urandom); priWrN = 1'($urandom); priAddr = pick[$urandom % 4];
      sec0EnN  = 1'($urandom); sec0WrN = 1'($urandom); sec0Addr = pick[$urandom % 4];
      sec1EnN  = 1'($urandom); sec1WrN = 1'($urandom); sec1Addr = pick[$urandom % 4];
      step();
    end
    idle(); step();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end

  initial begin
    #100000;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end
endmodule